// File: doc/BRIEF.md
# Bridge Parity Error Reporting Unit

This unit watches both sides of a two-sided bus bridge, the upstream (primary) side and the downstream (secondary) side, for parity faults. Each address or data phase is marked by a one-cycle strobe. The unit registers the 32-bit address/data value, the 4-bit command/byte-enable value and the parity bit for that phase. One clock later it checks them for even parity.

A detected fault is turned into actions according to which side saw it, what kind of phase it was, and two independent enables. The command-register response enable governs the primary side. The bridge-control response enable governs the secondary side. A system-error enable gates system-error reporting. The possible actions are:

- withholding the claim of a downstream-side transaction;
- letting a configuration write to the bridge's own registers complete;
- pulsing the active-low data-parity-error pins of either side;
- pulsing the active-low system-error pin;
- setting sticky status bits, which software clears by writing ones.

Top module: `bpe_unit`

## Requirements
- R1: Parity is even: a phase is faulty when the XOR of its 32 address/data bits, 4 command/byte-enable bits and parity bit is 1. The check is made in the clock after the phase strobe.
- R2: `sec_claim` is high in the cycle after a secondary address phase when `sec_claim_req` was set. It is forced low when that phase has a parity fault and `bctl_per_en` is 1.
- R3: When `bctl_per_en` is 0, a secondary address fault does not affect `sec_claim`, which follows `sec_claim_req`.
- R4: Any parity fault in a secondary address or data phase sets `status[2]`.
- R5: A secondary address fault drives `p_serr_n` low for one clock and sets `status[1]`, but only when `cmd_serr_en` and `bctl_per_en` are both 1.
- R6: A primary address fault sets `status[0]`. When `cmd_serr_en` and `cmd_per_en` are both 1, it also drives `p_serr_n` low for one clock and sets `status[1]`.
- R7: `cfg_wr_ack` is high in the cycle after a primary data phase flagged by `pri_cfg_wr`, whether or not that phase has a parity fault.
- R8: A configuration-write data fault drives `p_perr_n` low for exactly one clock, two clocks after the data phase, only when `cmd_per_en` is 1.
- R9: Any primary address or data fault sets `status[0]`, whatever the value of `cmd_per_en`.
- R10: A faulty read data phase received by the bridge pulses a PERR pin two clocks after the phase. On the primary side (`pri_rd_own`) it pulses `p_perr_n` when `cmd_per_en` is 1. On the secondary side (`sec_rd_own`) it pulses `s_perr_n` when `bctl_per_en` is 1.
- R11: A faulty data phase that is neither a configuration write nor an owned read pulses no PERR pin. It still sets the detected-fault bit of its side.
- R12: Status bits are sticky. While `stat_wr_en` is 1, each 1 in `stat_wr_data` clears the matching bit and each 0 leaves it alone. A bit being set in the same clock as its clear stays set.
- R13: After reset, `p_perr_n`, `s_perr_n` and `p_serr_n` are 1, and `status`, `sec_claim` and `cfg_wr_ack` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pri_addr_vld | input | 1 | Primary address phase strobe |
| pri_data_vld | input | 1 | Primary data phase strobe |
| pri_ad | input | AD_W | Primary address/data value |
| pri_cbe | input | CBE_W | Primary command/byte-enable value |
| pri_par | input | 1 | Primary parity bit |
| pri_cfg_wr | input | 1 | Data phase is a config write to the bridge's own registers |
| pri_rd_own | input | 1 | Data phase is read data received by the bridge on primary |
| sec_addr_vld | input | 1 | Secondary address phase strobe |
| sec_data_vld | input | 1 | Secondary data phase strobe |
| sec_ad | input | AD_W | Secondary address/data value |
| sec_cbe | input | CBE_W | Secondary command/byte-enable value |
| sec_par | input | 1 | Secondary parity bit |
| sec_rd_own | input | 1 | Data phase is read data received by the bridge on secondary |
| sec_claim_req | input | 1 | Address decode hit on secondary, valid with the strobe |
| cmd_per_en | input | 1 | Primary parity response enable |
| cmd_serr_en | input | 1 | System error report enable |
| bctl_per_en | input | 1 | Secondary parity response enable |
| stat_wr_en | input | 1 | Status write strobe |
| stat_wr_data | input | ST_W | Status write-one-to-clear mask |
| sec_claim | output | 1 | Permission to claim the secondary transaction |
| cfg_wr_ack | output | 1 | Config write completes |
| p_perr_n | output | 1 | Primary data parity error, active low |
| s_perr_n | output | 1 | Secondary data parity error, active low |
| p_serr_n | output | 1 | Primary system error, active low |
| status | output | ST_W | Sticky status: [0] primary fault, [1] system error signalled, [2] secondary fault |

## Verification
The checker module looks at every cycle. It confirms that a PERR pulse on either side appears only two clocks after a data phase of the right kind, taken while the right enable was set. It confirms that a system-error pulse is always matched by its status bit and by the system-error enable. It confirms that claims and configuration acknowledges only follow a matching phase, and that no status bit clears without a write-one to its position.

The effect of a fault, that is, a claim withheld or a pulse that should appear but does not, can only be shown by the bench scenarios. These drive deliberately corrupted parity under every combination of enables. They also show the same-cycle set-versus-clear ordering and simultaneous faults on both sides.

// File: rtl/bpe_pkg.sv
package bpe_pkg;

    localparam int NSIDE    = 2;
    localparam int SIDE_PRI = 0;
    localparam int SIDE_SEC = 1;

    // per-phase qualifier flags carried alongside the bus sample
    localparam int FL_W   = 3;
    localparam int FL_CFG = 0;
    localparam int FL_RD  = 1;
    localparam int FL_REQ = 2;

    // sticky status layout
    localparam int ST_W        = 3;
    localparam int ST_PRI_DPE  = 0;
    localparam int ST_SIG_SERR = 1;
    localparam int ST_SEC_DPE  = 2;

    typedef struct packed {
        logic            addr_seen;
        logic            data_seen;
        logic            addr_err;
        logic            data_err;
        logic [FL_W-1:0] flags;
    } chk_res_t;

    typedef struct packed {
        logic p_perr_n;
        logic s_perr_n;
        logic p_serr_n;
    } pin_t;

endpackage

// File: rtl/bpe_parity_chk.sv
module bpe_parity_chk
    import bpe_pkg::*;
#(
    parameter int AD_W  = 32,
    parameter int CBE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             addr_vld,
    input  logic             data_vld,
    input  logic [AD_W-1:0]  ad,
    input  logic [CBE_W-1:0] cbe,
    input  logic             par,
    input  logic [FL_W-1:0]  flags,
    output chk_res_t         res
);

    localparam int SAMPLE_W = AD_W + CBE_W + 1;

    typedef struct packed {
        logic                addr;
        logic                data;
        logic [SAMPLE_W-1:0] bits;
        logic [FL_W-1:0]     flags;
    } cap_t;

    cap_t cap_d, cap_q;
    logic odd;

    always_comb begin
        cap_d       = cap_q;
        cap_d.addr  = addr_vld;
        cap_d.data  = data_vld;
        if (addr_vld || data_vld) begin
            cap_d.bits  = {ad, cbe, par};
            cap_d.flags = flags;
        end else begin
            cap_d.flags = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    // even parity: the whole sample, parity included, has an even count of ones
    assign odd = ^cap_q.bits;

    always_comb begin
        res           = '0;
        res.addr_seen = cap_q.addr;
        res.data_seen = cap_q.data;
        res.addr_err  = cap_q.addr & odd;
        res.data_err  = cap_q.data & odd;
        res.flags     = cap_q.flags;
    end

endmodule

// File: rtl/bpe_policy.sv
module bpe_policy
    import bpe_pkg::*;
(
    input  chk_res_t [NSIDE-1:0] res,
    input  logic                 cmd_per_en,
    input  logic                 cmd_serr_en,
    input  logic                 bctl_per_en,
    output logic [NSIDE-1:0]     perr,
    output logic [NSIDE-1:0]     claim,
    output logic [NSIDE-1:0]     cfg_ack,
    output logic                 serr,
    output logic [ST_W-1:0]      set_mask
);

    logic [NSIDE-1:0] resp_en;
    logic [NSIDE-1:0] serr_side;
    logic [NSIDE-1:0] fault;

    assign resp_en[SIDE_PRI] = cmd_per_en;
    assign resp_en[SIDE_SEC] = bctl_per_en;

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        always_comb begin
            fault[s]     = res[s].addr_err | res[s].data_err;
            perr[s]      = res[s].data_err & resp_en[s]
                         & (res[s].flags[FL_CFG] | res[s].flags[FL_RD]);
            claim[s]     = res[s].addr_seen & res[s].flags[FL_REQ]
                         & ~(res[s].addr_err & resp_en[s]);
            cfg_ack[s]   = res[s].data_seen & res[s].flags[FL_CFG];
            serr_side[s] = res[s].addr_err & resp_en[s] & cmd_serr_en;
        end
    end

    always_comb begin
        serr                  = |serr_side;
        set_mask              = '0;
        set_mask[ST_PRI_DPE]  = fault[SIDE_PRI];
        set_mask[ST_SEC_DPE]  = fault[SIDE_SEC];
        set_mask[ST_SIG_SERR] = serr;
    end

endmodule

// File: rtl/bpe_status.sv
module bpe_status
    import bpe_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ST_W-1:0] set_mask,
    input  logic            wr_en,
    input  logic [ST_W-1:0] wr_data,
    output logic [ST_W-1:0] status
);

    logic [ST_W-1:0] st_d, st_q;
    logic [ST_W-1:0] clr;

    always_comb begin
        clr  = wr_en ? wr_data : '0;
        // a new event outranks a clear in the same clock
        st_d = (st_q & ~clr) | set_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status = st_q;

endmodule

// File: rtl/bpe_unit.sv
module bpe_unit
    import bpe_pkg::*;
#(
    parameter int AD_W  = 32,
    parameter int CBE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pri_addr_vld,
    input  logic             pri_data_vld,
    input  logic [AD_W-1:0]  pri_ad,
    input  logic [CBE_W-1:0] pri_cbe,
    input  logic             pri_par,
    input  logic             pri_cfg_wr,
    input  logic             pri_rd_own,
    input  logic             sec_addr_vld,
    input  logic             sec_data_vld,
    input  logic [AD_W-1:0]  sec_ad,
    input  logic [CBE_W-1:0] sec_cbe,
    input  logic             sec_par,
    input  logic             sec_rd_own,
    input  logic             sec_claim_req,
    input  logic             cmd_per_en,
    input  logic             cmd_serr_en,
    input  logic             bctl_per_en,
    input  logic             stat_wr_en,
    input  logic [ST_W-1:0]  stat_wr_data,
    output logic             sec_claim,
    output logic             cfg_wr_ack,
    output logic             p_perr_n,
    output logic             s_perr_n,
    output logic             p_serr_n,
    output logic [ST_W-1:0]  status
);

    logic [NSIDE-1:0]            addr_vld_v;
    logic [NSIDE-1:0]            data_vld_v;
    logic [NSIDE-1:0][AD_W-1:0]  ad_v;
    logic [NSIDE-1:0][CBE_W-1:0] cbe_v;
    logic [NSIDE-1:0]            par_v;
    logic [NSIDE-1:0][FL_W-1:0]  flags_v;
    chk_res_t [NSIDE-1:0]        res_v;

    logic [NSIDE-1:0] perr_v;
    logic [NSIDE-1:0] claim_v;
    logic [NSIDE-1:0] cfg_ack_v;
    logic             serr_ev;
    logic [ST_W-1:0]  set_mask;

    pin_t pins_d, pins_q;

    // gather both sides into side-indexed vectors
    always_comb begin
        addr_vld_v[SIDE_PRI] = pri_addr_vld;
        data_vld_v[SIDE_PRI] = pri_data_vld;
        ad_v[SIDE_PRI]       = pri_ad;
        cbe_v[SIDE_PRI]      = pri_cbe;
        par_v[SIDE_PRI]      = pri_par;
        flags_v[SIDE_PRI]         = '0;
        flags_v[SIDE_PRI][FL_CFG] = pri_cfg_wr;
        flags_v[SIDE_PRI][FL_RD]  = pri_rd_own;

        addr_vld_v[SIDE_SEC] = sec_addr_vld;
        data_vld_v[SIDE_SEC] = sec_data_vld;
        ad_v[SIDE_SEC]       = sec_ad;
        cbe_v[SIDE_SEC]      = sec_cbe;
        par_v[SIDE_SEC]      = sec_par;
        flags_v[SIDE_SEC]         = '0;
        flags_v[SIDE_SEC][FL_RD]  = sec_rd_own;
        flags_v[SIDE_SEC][FL_REQ] = sec_claim_req;
    end

    for (genvar s = 0; s < NSIDE; s++) begin : g_chk
        bpe_parity_chk #(
            .AD_W  (AD_W),
            .CBE_W (CBE_W)
        ) chk_u (
            .clk      (clk),
            .rst_n    (rst_n),
            .addr_vld (addr_vld_v[s]),
            .data_vld (data_vld_v[s]),
            .ad       (ad_v[s]),
            .cbe      (cbe_v[s]),
            .par      (par_v[s]),
            .flags    (flags_v[s]),
            .res      (res_v[s])
        );
    end

    bpe_policy policy_u (
        .res         (res_v),
        .cmd_per_en  (cmd_per_en),
        .cmd_serr_en (cmd_serr_en),
        .bctl_per_en (bctl_per_en),
        .perr        (perr_v),
        .claim       (claim_v),
        .cfg_ack     (cfg_ack_v),
        .serr        (serr_ev),
        .set_mask    (set_mask)
    );

    bpe_status status_u (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_mask (set_mask),
        .wr_en    (stat_wr_en),
        .wr_data  (stat_wr_data),
        .status   (status)
    );

    always_comb begin
        pins_d          = pins_q;
        pins_d.p_perr_n = ~perr_v[SIDE_PRI];
        pins_d.s_perr_n = ~perr_v[SIDE_SEC];
        pins_d.p_serr_n = ~serr_ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pins_q <= '1;
        end else begin
            pins_q <= pins_d;
        end
    end

    assign p_perr_n   = pins_q.p_perr_n;
    assign s_perr_n   = pins_q.s_perr_n;
    assign p_serr_n   = pins_q.p_serr_n;
    assign sec_claim  = claim_v[SIDE_SEC];
    assign cfg_wr_ack = cfg_ack_v[SIDE_PRI];

endmodule

// File: rtl/bpe_unit_chk.sv
module bpe_unit_chk
    import bpe_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            pri_data_vld,
    input logic            pri_cfg_wr,
    input logic            pri_rd_own,
    input logic            sec_addr_vld,
    input logic            sec_data_vld,
    input logic            sec_rd_own,
    input logic            sec_claim_req,
    input logic            cmd_per_en,
    input logic            cmd_serr_en,
    input logic            bctl_per_en,
    input logic            stat_wr_en,
    input logic [ST_W-1:0] stat_wr_data,
    input logic            sec_claim,
    input logic            cfg_wr_ack,
    input logic            p_perr_n,
    input logic            s_perr_n,
    input logic            p_serr_n,
    input logic [ST_W-1:0] status
);

    logic [ST_W-1:0] prev_stat_q;
    logic [ST_W-1:0] prev_clr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_stat_q <= '0;
            prev_clr_q  <= '0;
        end else begin
            prev_stat_q <= status;
            prev_clr_q  <= stat_wr_en ? stat_wr_data : '0;
        end
    end

    // R8
    p_perr_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !p_perr_n |-> $past(pri_data_vld && (pri_cfg_wr || pri_rd_own), 2));

    // R8
    p_perr_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !p_perr_n |-> $past(cmd_per_en));

    // R10
    s_perr_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s_perr_n |-> ($past(sec_data_vld && sec_rd_own, 2) && $past(bctl_per_en)));

    // R5
    serr_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !p_serr_n |-> $past(cmd_serr_en));

    // R5
    serr_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !p_serr_n |-> status[ST_SIG_SERR]);

    // R2
    claim_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_claim |-> $past(sec_addr_vld && sec_claim_req));

    // R7
    cfg_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_ack == $past(pri_data_vld && pri_cfg_wr));

    // R12
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((prev_stat_q & ~prev_clr_q & ~status) == '0));

endmodule

bind bpe_unit bpe_unit_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .pri_data_vld  (pri_data_vld),
    .pri_cfg_wr    (pri_cfg_wr),
    .pri_rd_own    (pri_rd_own),
    .sec_addr_vld  (sec_addr_vld),
    .sec_data_vld  (sec_data_vld),
    .sec_rd_own    (sec_rd_own),
    .sec_claim_req (sec_claim_req),
    .cmd_per_en    (cmd_per_en),
    .cmd_serr_en   (cmd_serr_en),
    .bctl_per_en   (bctl_per_en),
    .stat_wr_en    (stat_wr_en),
    .stat_wr_data  (stat_wr_data),
    .sec_claim     (sec_claim),
    .cfg_wr_ack    (cfg_wr_ack),
    .p_perr_n      (p_perr_n),
    .s_perr_n      (s_perr_n),
    .p_serr_n      (p_serr_n),
    .status        (status)
);

// File: tb/bpe_unit_tb.sv
`timescale 1ns/1ps
module bpe_unit_tb_top;

    localparam int AD_W  = 32;
    localparam int CBE_W = 4;
    localparam int ST_W  = 3;
    localparam int NVEC  = 15;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pri_addr_vld = 0, pri_data_vld = 0;
    logic [AD_W-1:0]  pri_ad = '0;
    logic [CBE_W-1:0] pri_cbe = '0;
    logic             pri_par = 0, pri_cfg_wr = 0, pri_rd_own = 0;
    logic             sec_addr_vld = 0, sec_data_vld = 0;
    logic [AD_W-1:0]  sec_ad = '0;
    logic [CBE_W-1:0] sec_cbe = '0;
    logic             sec_par = 0, sec_rd_own = 0, sec_claim_req = 0;
    logic             cmd_per_en = 0, cmd_serr_en = 0, bctl_per_en = 0;
    logic             stat_wr_en = 0;
    logic [ST_W-1:0]  stat_wr_data = '0;
    logic             sec_claim, cfg_wr_ack, p_perr_n, s_perr_n, p_serr_n;
    logic [ST_W-1:0]  status;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    bpe_unit #(.AD_W(AD_W), .CBE_W(CBE_W)) dut_i (.*);

    typedef struct packed {
        logic sec, is_addr, cfg, rd;
        logic bad, cper, cserr, bper;
        logic req, e_claim, e_pperr, e_sperr;
        logic e_serr;
        logic [2:0] e_stat;
    } vec_t;

    // status bits: [0] primary fault, [1] system error, [2] secondary fault
    localparam logic [15:0] VEC_TBL [0:NVEC-1] = '{
        16'b1100_0111_1100_0000,   // R3 clean sec address, claimed
        16'b1100_1111_1000_1110,   // R2 R5 suppress + SERR
        16'b1100_1110_1100_0100,   // R3 response off, still claimed
        16'b1100_1101_1000_0100,   // R2 R5 no SERR without enable
        16'b1100_1110_0000_0100,   // R4 fault, no decode hit
        16'b0010_1100_0010_0001,   // R8 cfg write fault, PERR
        16'b0010_1001_0000_0001,   // R8 R9 cfg write fault, response off
        16'b0010_0101_0000_0000,   // R1 clean cfg write
        16'b0001_1100_0010_0001,   // R10 primary read fault
        16'b1001_1001_0001_0100,   // R10 secondary read fault
        16'b1001_1100_0000_0100,   // R10 secondary read, bctl off
        16'b0100_1110_0000_1011,   // R6 primary address fault + SERR
        16'b0100_1011_0000_0001,   // R6 primary address, cper off
        16'b1000_1111_0000_0100,   // R11 forwarded write data fault
        16'b0100_0111_0000_0000    // R1 clean primary address
    };

    task automatic check(string req, logic [3:0] act, logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(vec_t v, int idx);
        logic [AD_W-1:0]  ad;
        logic [CBE_W-1:0] cbe;
        logic             par;
        ad  = 32'h5A3C_0F00 + idx * 32'h0101_0013;
        cbe = CBE_W'(idx);
        par = (^{ad, cbe}) ^ v.bad;
        cmd_per_en  = v.cper;
        cmd_serr_en = v.cserr;
        bctl_per_en = v.bper;
        if (v.sec) begin
            sec_ad = ad; sec_cbe = cbe; sec_par = par;
            sec_addr_vld  = v.is_addr;
            sec_data_vld  = !v.is_addr;
            sec_rd_own    = v.rd;
            sec_claim_req = v.req;
        end else begin
            pri_ad = ad; pri_cbe = cbe; pri_par = par;
            pri_addr_vld = v.is_addr;
            pri_data_vld = !v.is_addr;
            pri_cfg_wr   = v.cfg;
            pri_rd_own   = v.rd;
        end
    endtask

    task automatic idle();
        pri_addr_vld = 0; pri_data_vld = 0; pri_cfg_wr = 0; pri_rd_own = 0;
        sec_addr_vld = 0; sec_data_vld = 0; sec_rd_own = 0; sec_claim_req = 0;
    endtask

    task automatic clear_all();
        @(negedge clk);
        stat_wr_en = 1; stat_wr_data = '1;
        @(negedge clk);
        stat_wr_en = 0; stat_wr_data = '0;
        check("R12 clear", {1'b0, status}, 4'h0);
    endtask

    initial begin
        repeat (4000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R13 reset state
        check("R13 pins", {1'b0, p_perr_n, s_perr_n, p_serr_n}, 4'h7);
        check("R13 status", {1'b0, status}, 4'h0);
        check("R13 claim/ack", {2'b0, sec_claim, cfg_wr_ack}, 4'h0);
        rst_n = 1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            vec_t v;
            v = vec_t'(VEC_TBL[i]);
            drive(v, i);
            @(negedge clk);
            idle();
            check($sformatf("R2 R3 R7 claim/ack vec%0d", i),
                  {2'b0, sec_claim, cfg_wr_ack},
                  {2'b0, v.e_claim, (!v.sec && !v.is_addr && v.cfg)});
            @(negedge clk);
            check($sformatf("R1 R8 R10 R11 R5 R6 pins vec%0d", i),
                  {1'b0, p_perr_n, s_perr_n, p_serr_n},
                  {1'b0, !v.e_pperr, !v.e_sperr, !v.e_serr});
            check($sformatf("R4 R9 R5 R6 status vec%0d", i),
                  {1'b0, status}, {1'b0, v.e_stat});
            @(negedge clk);
            check($sformatf("R8 one-clock pulse vec%0d", i),
                  {1'b0, p_perr_n, s_perr_n, p_serr_n}, 4'h7);
            check($sformatf("R12 sticky vec%0d", i), {1'b0, status}, {1'b0, v.e_stat});
            clear_all();
        end

        // R12 selective clear: set bits 0 and 1, clear only bit 1
        drive(vec_t'(VEC_TBL[11]), 11);
        @(negedge clk); idle();
        @(negedge clk);
        stat_wr_en = 1; stat_wr_data = 3'b010;
        @(negedge clk);
        check("R12 partial clear", {1'b0, status}, 4'h1);
        stat_wr_data = 3'b000;
        @(negedge clk);
        stat_wr_en = 0;
        check("R12 zero write", {1'b0, status}, 4'h1);
        clear_all();

        // R12 set in the same clock as its clear keeps the bit
        drive(vec_t'(VEC_TBL[5]), 5);
        @(negedge clk); idle();
        stat_wr_en = 1; stat_wr_data = 3'b001;
        @(negedge clk);
        stat_wr_en = 0; stat_wr_data = '0;
        check("R12 set beats clear", {1'b0, status}, 4'h1);
        clear_all();

        // R8 R10 faults on both sides in the same cycle
        drive(vec_t'(VEC_TBL[5]), 5);
        drive(vec_t'(VEC_TBL[9]), 9);
        cmd_per_en = 1;
        @(negedge clk); idle();
        @(negedge clk);
        check("R8 R10 both sides pins", {1'b0, p_perr_n, s_perr_n, p_serr_n}, 4'h1);
        check("R4 R9 both sides status", {1'b0, status}, 4'h5);
        clear_all();

        // R8 back-to-back faulty cfg writes give two PERR clocks
        drive(vec_t'(VEC_TBL[5]), 5);
        @(negedge clk);
        drive(vec_t'(VEC_TBL[5]), 6);
        @(negedge clk); idle();
        check("R8 back-to-back first", {3'b0, p_perr_n}, 4'h0);
        @(negedge clk);
        check("R8 back-to-back second", {3'b0, p_perr_n}, 4'h0);
        @(negedge clk);
        check("R8 back-to-back end", {3'b0, p_perr_n}, 4'h1);
        clear_all();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule